// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer with Address-Space Tags

This block is a fully associative translation buffer. Each entry covers a pair of adjacent virtual pages, an even page and an odd page, under one virtual page-pair number. An entry also holds its own page mask, an address-space tag and a global flag. Each half of the pair has its own physical frame number, a 3-bit cache attribute, a dirty bit and a valid bit. The requester picks the half with a single select bit.

Two independent combinational ports search the table. The lookup port returns a hit flag, the index of the winning entry and the fields of the selected half. The probe port returns only the index of the matching entry, or an all-ones code when nothing matches. A single write port replaces a whole entry at the next clock edge. A flush clears the whole table. A round-robin replacement pointer can be read back, and it can be advanced in the same cycle.

A read-back port shows any entry, or the entry under the pointer, as packed words. Software refill code can use these words directly.

Top module: `tlb_pair_asid`

## Requirements
- R1: An entry matches a search when the search VPN and the stored VPN are equal on every bit where that entry's mask bit is 0 (mask bits at 1 are ignored), and either the entry's global flag is 1 or its stored ASID equals the search ASID.
- R2: When several entries match, the lookup and the probe both report the lowest matching index.
- R3: The probe result is {1'b0, index} for a match and all ones (IDX_W+1 bits, 5'h1F at default size) when no entry matches. The lookup hit flag agrees with the probe whenever both ports are given the same VPN and ASID.
- R4: A write with wr_en=1 and wr_idx < N_ENTRIES replaces every field of that entry, visible from the next clock edge. A write with wr_idx >= N_ENTRIES changes no entry.
- R5: flush=1 clears every field of every entry (VPN, mask, ASID, global, frames, attributes, dirty and valid) and sets the replacement pointer to 0 at the next edge. Flush takes priority over a write and over an advance in the same cycle.
- R6: Read-back words use these formats: the low word of each half is PFN<<6 | attr<<3 | dirty<<2 | valid<<1 | global; the high word is VPN<<11 | ASID; the mask word is mask<<11.
- R7: nr_adv=1 moves the replacement pointer by one per edge, wrapping from N_ENTRIES-1 to 0. With rd_use_nr=1, the read-back port shows the entry under the current pointer, including in a cycle that also advances it.
- R8: lk_odd=0 selects the even half and lk_odd=1 selects the odd half for lk_pfn, lk_attr, lk_dirty and lk_valid. An entry whose valid bits are 0 still matches, and it reports lk_valid=0.
- R9: After reset the table and the pointer are in the same all-zero state that a flush leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup page-pair number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_odd | input | 1 | Lookup half select (1 = odd page) |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_idx | output | IDX_W | Index of winning entry |
| lk_pfn | output | PFN_W | Frame number of selected half (0 on miss) |
| lk_attr | output | 3 | Cache attribute of selected half |
| lk_dirty | output | 1 | Dirty bit of selected half |
| lk_valid | output | 1 | Valid bit of selected half |
| pr_vpn | input | VPN_W | Probe page-pair number |
| pr_asid | input | ASID_W | Probe address-space tag |
| pr_result | output | IDX_W+1 | Matching index or all ones |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W+1 | Target entry index |
| wr_vpn | input | VPN_W | New page-pair number |
| wr_mask | input | VPN_W | New page mask (1 = ignore bit) |
| wr_asid | input | ASID_W | New address-space tag |
| wr_glob | input | 1 | New global flag |
| wr_pfn_even | input | PFN_W | Even-half frame number |
| wr_attr_even | input | 3 | Even-half cache attribute |
| wr_dirty_even | input | 1 | Even-half dirty bit |
| wr_valid_even | input | 1 | Even-half valid bit |
| wr_pfn_odd | input | PFN_W | Odd-half frame number |
| wr_attr_odd | input | 3 | Odd-half cache attribute |
| wr_dirty_odd | input | 1 | Odd-half dirty bit |
| wr_valid_odd | input | 1 | Odd-half valid bit |
| flush | input | 1 | Clear all entries and pointer |
| nr_adv | input | 1 | Advance replacement pointer |
| nr_ptr | output | IDX_W | Replacement pointer |
| rd_idx | input | IDX_W | Read-back index |
| rd_use_nr | input | 1 | Read back the entry under the pointer instead |
| rd_lo_even | output | PFN_W+6 | Even-half packed word |
| rd_lo_odd | output | PFN_W+6 | Odd-half packed word |
| rd_hi | output | VPN_W+11 | Packed VPN and ASID word |
| rd_mask | output | VPN_W+11 | Packed mask word |

## Verification
The assertions check, on every cycle, the behaviour that can be judged from the ports alone:
- the probe result stays in range or is the all-ones code;
- the lookup and the probe agree on a hit when both are given the same search;
- the pointer steps by exactly one with wrap-around, and holds otherwise;
- after a flush the read-back words are zero;
- an out-of-range write leaves the read-back words unchanged.

Only the bench scenarios can show the rest, because the expected values depend on known table contents:
- whether masked bits are ignored;
- whether the global flag overrides the ASID;
- which index wins on an overlap;
- which half supplies the frame;
- whether an invalid half still hits.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
   // Bit layout of the packed read-back words
   localparam int LO_GLOB_BIT  = 0;
   localparam int LO_VALID_BIT = 1;
   localparam int LO_DIRTY_BIT = 2;
   localparam int LO_ATTR_LSB  = 3;
   localparam int LO_PFN_LSB   = 6;
   localparam int HI_VPN_LSB   = 11;
   localparam int ATTR_W       = 3;

   typedef enum logic {
      HALF_EVEN = 1'b0,
      HALF_ODD  = 1'b1
   } half_e;
endpackage

// File: rtl/tlb_pair_store.sv
module tlb_pair_store
   import tlb_pair_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int VPN_W     = 19,
   parameter int ASID_W    = 8,
   parameter int PFN_W     = 24,
   parameter int IDX_W     = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               flush,
   input  logic                               wr_en,
   input  logic [IDX_W:0]                     wr_idx,
   input  logic [VPN_W-1:0]                   wr_vpn,
   input  logic [VPN_W-1:0]                   wr_mask,
   input  logic [ASID_W-1:0]                  wr_asid,
   input  logic                               wr_glob,
   input  logic [1:0][PFN_W-1:0]              wr_pfn,
   input  logic [1:0][ATTR_W-1:0]             wr_attr,
   input  logic [1:0]                         wr_dirty,
   input  logic [1:0]                         wr_valid,
   output logic [VPN_W-1:0]                   vpn_q   [N_ENTRIES],
   output logic [VPN_W-1:0]                   mask_q  [N_ENTRIES],
   output logic [ASID_W-1:0]                  asid_q  [N_ENTRIES],
   output logic [N_ENTRIES-1:0]               glob_q,
   output logic [1:0][PFN_W-1:0]              pfn_q   [N_ENTRIES],
   output logic [1:0][ATTR_W-1:0]             attr_q  [N_ENTRIES],
   output logic [1:0]                         dirty_q [N_ENTRIES],
   output logic [1:0]                         valid_q [N_ENTRIES]
);
   for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
      logic                   sel;
      logic [VPN_W-1:0]       vpn_r;
      logic [VPN_W-1:0]       mask_r;
      logic [ASID_W-1:0]      asid_r;
      logic                   glob_r;
      logic [1:0][PFN_W-1:0]  pfn_r;
      logic [1:0][ATTR_W-1:0] attr_r;
      logic [1:0]             dirty_r;
      logic [1:0]             valid_r;

      assign sel = wr_en && (wr_idx == (IDX_W+1)'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vpn_r   <= '0;
            mask_r  <= '0;
            asid_r  <= '0;
            glob_r  <= 1'b0;
            pfn_r   <= '0;
            attr_r  <= '0;
            dirty_r <= '0;
            valid_r <= '0;
         end else if (flush) begin
            vpn_r   <= '0;
            mask_r  <= '0;
            asid_r  <= '0;
            glob_r  <= 1'b0;
            pfn_r   <= '0;
            attr_r  <= '0;
            dirty_r <= '0;
            valid_r <= '0;
         end else if (sel) begin
            vpn_r   <= wr_vpn;
            mask_r  <= wr_mask;
            asid_r  <= wr_asid;
            glob_r  <= wr_glob;
            pfn_r   <= wr_pfn;
            attr_r  <= wr_attr;
            dirty_r <= wr_dirty;
            valid_r <= wr_valid;
         end
      end

      assign vpn_q[e]   = vpn_r;
      assign mask_q[e]  = mask_r;
      assign asid_q[e]  = asid_r;
      assign glob_q[e]  = glob_r;
      assign pfn_q[e]   = pfn_r;
      assign attr_q[e]  = attr_r;
      assign dirty_q[e] = dirty_r;
      assign valid_q[e] = valid_r;
   end
endmodule

// File: rtl/tlb_pair_match.sv
module tlb_pair_match #(
   parameter int N_ENTRIES = 16,
   parameter int VPN_W     = 19,
   parameter int ASID_W    = 8,
   parameter int IDX_W     = 4
) (
   input  logic [VPN_W-1:0]     q_vpn,
   input  logic [ASID_W-1:0]    q_asid,
   input  logic [VPN_W-1:0]     vpn_q  [N_ENTRIES],
   input  logic [VPN_W-1:0]     mask_q [N_ENTRIES],
   input  logic [ASID_W-1:0]    asid_q [N_ENTRIES],
   input  logic [N_ENTRIES-1:0] glob_q,
   output logic                 hit,
   output logic [IDX_W-1:0]     idx
);
   logic [N_ENTRIES-1:0] hv;

   for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
      logic tag_eq;
      logic space_ok;
      assign tag_eq   = (((q_vpn ^ vpn_q[e]) & ~mask_q[e]) == '0);
      assign space_ok = glob_q[e] || (asid_q[e] == q_asid);
      assign hv[e]    = tag_eq && space_ok;
   end

   // Lowest index has priority: scan from the top down, last hit wins
   always_comb begin
      idx = '0;
      for (int e = N_ENTRIES - 1; e >= 0; e--) begin
         if (hv[e]) idx = IDX_W'(e);
      end
   end

   assign hit = |hv;
endmodule

// File: rtl/tlb_pair_victim.sv
module tlb_pair_victim #(
   parameter int N_ENTRIES = 16,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (flush)  ptr <= '0;
      else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/tlb_pair_asid.sv
module tlb_pair_asid
   import tlb_pair_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int VPN_W     = 19,
   parameter int ASID_W    = 8,
   parameter int PFN_W     = 24,
   localparam int IDX_W    = $clog2(N_ENTRIES),
   localparam int LO_W     = PFN_W + LO_PFN_LSB,
   localparam int HI_W     = VPN_W + HI_VPN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_odd,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [2:0]        lk_attr,
   output logic              lk_dirty,
   output logic              lk_valid,
   input  logic [VPN_W-1:0]  pr_vpn,
   input  logic [ASID_W-1:0] pr_asid,
   output logic [IDX_W:0]    pr_result,
   input  logic              wr_en,
   input  logic [IDX_W:0]    wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [VPN_W-1:0]  wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glob,
   input  logic [PFN_W-1:0]  wr_pfn_even,
   input  logic [2:0]        wr_attr_even,
   input  logic              wr_dirty_even,
   input  logic              wr_valid_even,
   input  logic [PFN_W-1:0]  wr_pfn_odd,
   input  logic [2:0]        wr_attr_odd,
   input  logic              wr_dirty_odd,
   input  logic              wr_valid_odd,
   input  logic              flush,
   input  logic              nr_adv,
   output logic [IDX_W-1:0]  nr_ptr,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_use_nr,
   output logic [LO_W-1:0]   rd_lo_even,
   output logic [LO_W-1:0]   rd_lo_odd,
   output logic [HI_W-1:0]   rd_hi,
   output logic [HI_W-1:0]   rd_mask
);
   // Elaboration-time parameter checks
   if (N_ENTRIES < 2) begin : g_bad_n
      $error("tlb_pair_asid: N_ENTRIES must be at least 2");
   end
   if (ASID_W < 1 || ASID_W > HI_VPN_LSB) begin : g_bad_asid
      $error("tlb_pair_asid: ASID_W must lie in 1..11");
   end
   if (VPN_W < 1 || PFN_W < 1) begin : g_bad_w
      $error("tlb_pair_asid: VPN_W and PFN_W must be positive");
   end

   localparam logic [IDX_W:0] NO_MATCH = '1;

   logic [VPN_W-1:0]        vpn_q   [N_ENTRIES];
   logic [VPN_W-1:0]        mask_q  [N_ENTRIES];
   logic [ASID_W-1:0]       asid_q  [N_ENTRIES];
   logic [N_ENTRIES-1:0]    glob_q;
   logic [1:0][PFN_W-1:0]   pfn_q   [N_ENTRIES];
   logic [1:0][ATTR_W-1:0]  attr_q  [N_ENTRIES];
   logic [1:0]              dirty_q [N_ENTRIES];
   logic [1:0]              valid_q [N_ENTRIES];

   tlb_pair_store #(
      .N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
      .PFN_W(PFN_W), .IDX_W(IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_vpn   (wr_vpn),
      .wr_mask  (wr_mask),
      .wr_asid  (wr_asid),
      .wr_glob  (wr_glob),
      .wr_pfn   ({wr_pfn_odd, wr_pfn_even}),
      .wr_attr  ({wr_attr_odd, wr_attr_even}),
      .wr_dirty ({wr_dirty_odd, wr_dirty_even}),
      .wr_valid ({wr_valid_odd, wr_valid_even}),
      .vpn_q    (vpn_q),
      .mask_q   (mask_q),
      .asid_q   (asid_q),
      .glob_q   (glob_q),
      .pfn_q    (pfn_q),
      .attr_q   (attr_q),
      .dirty_q  (dirty_q),
      .valid_q  (valid_q)
   );

   // Lookup search
   logic [IDX_W-1:0] lk_win;
   logic             lk_found;

   tlb_pair_match #(
      .N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
   ) u_lk_match (
      .q_vpn  (lk_vpn),
      .q_asid (lk_asid),
      .vpn_q  (vpn_q),
      .mask_q (mask_q),
      .asid_q (asid_q),
      .glob_q (glob_q),
      .hit    (lk_found),
      .idx    (lk_win)
   );

   half_e lk_half;
   assign lk_half = half_e'(lk_odd);

   always_comb begin
      lk_hit   = lk_found;
      lk_idx   = lk_win;
      lk_pfn   = '0;
      lk_attr  = '0;
      lk_dirty = 1'b0;
      lk_valid = 1'b0;
      if (lk_found) begin
         if (lk_half == HALF_ODD) begin
            lk_pfn   = pfn_q[lk_win][1];
            lk_attr  = attr_q[lk_win][1];
            lk_dirty = dirty_q[lk_win][1];
            lk_valid = valid_q[lk_win][1];
         end else begin
            lk_pfn   = pfn_q[lk_win][0];
            lk_attr  = attr_q[lk_win][0];
            lk_dirty = dirty_q[lk_win][0];
            lk_valid = valid_q[lk_win][0];
         end
      end
   end

   // Probe search
   logic [IDX_W-1:0] pr_win;
   logic             pr_found;

   tlb_pair_match #(
      .N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
   ) u_pr_match (
      .q_vpn  (pr_vpn),
      .q_asid (pr_asid),
      .vpn_q  (vpn_q),
      .mask_q (mask_q),
      .asid_q (asid_q),
      .glob_q (glob_q),
      .hit    (pr_found),
      .idx    (pr_win)
   );

   assign pr_result = pr_found ? {1'b0, pr_win} : NO_MATCH;

   // Replacement pointer
   tlb_pair_victim #(
      .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)
   ) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .adv   (nr_adv),
      .ptr   (nr_ptr)
   );

   // Read-back port
   logic [IDX_W-1:0] rsel;
   assign rsel = rd_use_nr ? nr_ptr : rd_idx;

   always_comb begin
      rd_lo_even = '0;
      rd_lo_odd  = '0;
      rd_hi      = '0;
      rd_mask    = '0;
      if (32'(rsel) < N_ENTRIES) begin
         rd_lo_even = {pfn_q[rsel][0], attr_q[rsel][0], dirty_q[rsel][0],
                       valid_q[rsel][0], glob_q[rsel]};
         rd_lo_odd  = {pfn_q[rsel][1], attr_q[rsel][1], dirty_q[rsel][1],
                       valid_q[rsel][1], glob_q[rsel]};
         rd_hi      = (HI_W'(vpn_q[rsel]) << HI_VPN_LSB) | HI_W'(asid_q[rsel]);
         rd_mask    = HI_W'(mask_q[rsel]) << HI_VPN_LSB;
      end
   end
endmodule

// File: rtl/tlb_pair_chk.sv
module tlb_pair_chk #(
   parameter int N_ENTRIES = 16,
   parameter int VPN_W     = 19,
   parameter int ASID_W    = 8,
   parameter int PFN_W     = 24,
   localparam int IDX_W    = $clog2(N_ENTRIES),
   localparam int LO_W     = PFN_W + 6,
   localparam int HI_W     = VPN_W + 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [VPN_W-1:0]  lk_vpn,
   input logic [ASID_W-1:0] lk_asid,
   input logic              lk_hit,
   input logic [VPN_W-1:0]  pr_vpn,
   input logic [ASID_W-1:0] pr_asid,
   input logic [IDX_W:0]    pr_result,
   input logic              wr_en,
   input logic [IDX_W:0]    wr_idx,
   input logic              flush,
   input logic              nr_adv,
   input logic [IDX_W-1:0]  nr_ptr,
   input logic [IDX_W-1:0]  rd_idx,
   input logic              rd_use_nr,
   input logic [LO_W-1:0]   rd_lo_even,
   input logic [LO_W-1:0]   rd_lo_odd,
   input logic [HI_W-1:0]   rd_hi,
   input logic [HI_W-1:0]   rd_mask
);
   localparam logic [IDX_W:0]   NO_MATCH = '1;
   localparam logic [IDX_W-1:0] LAST     = IDX_W'(N_ENTRIES - 1);

   p_probe_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_result != NO_MATCH) |-> (32'(pr_result) < N_ENTRIES));

   p_lookup_probe_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vpn == pr_vpn && lk_asid == pr_asid) |-> (lk_hit == (pr_result != NO_MATCH)));

   p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (nr_ptr == '0 && rd_lo_even == '0 && rd_lo_odd == '0
                 && rd_hi == '0 && rd_mask == '0));

   p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (nr_adv && !flush) |=>
         (nr_ptr == (($past(nr_ptr) == LAST) ? '0 : IDX_W'($past(nr_ptr) + 1'b1))));

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!nr_adv && !flush) |=> $stable(nr_ptr));

   p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(nr_ptr) < N_ENTRIES);

   p_oob_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && 32'(wr_idx) >= N_ENTRIES && !flush && !rd_use_nr)
         ##1 (!rd_use_nr && $stable(rd_idx))
      |-> ($stable(rd_hi) && $stable(rd_mask) && $stable(rd_lo_even) && $stable(rd_lo_odd)));
endmodule

bind tlb_pair_asid tlb_pair_chk #(
   .N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_vpn     (lk_vpn),
   .lk_asid    (lk_asid),
   .lk_hit     (lk_hit),
   .pr_vpn     (pr_vpn),
   .pr_asid    (pr_asid),
   .pr_result  (pr_result),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .flush      (flush),
   .nr_adv     (nr_adv),
   .nr_ptr     (nr_ptr),
   .rd_idx     (rd_idx),
   .rd_use_nr  (rd_use_nr),
   .rd_lo_even (rd_lo_even),
   .rd_lo_odd  (rd_lo_odd),
   .rd_hi      (rd_hi),
   .rd_mask    (rd_mask)
);

// File: tb/tb_tlb_pair_asid.sv
module tb_tlb_pair_asid;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [18:0] lk_vpn;
   logic [7:0]  lk_asid;
   logic        lk_odd;
   logic        lk_hit;
   logic [3:0]  lk_idx;
   logic [23:0] lk_pfn;
   logic [2:0]  lk_attr;
   logic        lk_dirty;
   logic        lk_valid;
   logic [18:0] pr_vpn;
   logic [7:0]  pr_asid;
   logic [4:0]  pr_result;
   logic        wr_en;
   logic [4:0]  wr_idx;
   logic [18:0] wr_vpn;
   logic [18:0] wr_mask;
   logic [7:0]  wr_asid;
   logic        wr_glob;
   logic [23:0] wr_pfn_even;
   logic [2:0]  wr_attr_even;
   logic        wr_dirty_even;
   logic        wr_valid_even;
   logic [23:0] wr_pfn_odd;
   logic [2:0]  wr_attr_odd;
   logic        wr_dirty_odd;
   logic        wr_valid_odd;
   logic        flush;
   logic        nr_adv;
   logic [3:0]  nr_ptr;
   logic [3:0]  rd_idx;
   logic        rd_use_nr;
   logic [29:0] rd_lo_even;
   logic [29:0] rd_lo_odd;
   logic [29:0] rd_hi;
   logic [29:0] rd_mask;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   tlb_pair_asid dut (.*);

   typedef struct packed {
      logic [18:0] vpn;
      logic [7:0]  asid;
      logic        odd;
      logic        hit;
      logic [3:0]  idx;
      logic [23:0] pfn;
      logic [2:0]  attr;
      logic        dirty;
      logic        valid;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{19'h100, 8'h05, 1'b0, 1'b1, 4'd0, 24'h111, 3'd3, 1'b1, 1'b1},
      '{19'h100, 8'h05, 1'b1, 1'b1, 4'd0, 24'h222, 3'd2, 1'b0, 1'b1},
      '{19'h100, 8'h06, 1'b0, 1'b0, 4'd0, 24'h000, 3'd0, 1'b0, 1'b0},
      '{19'h200, 8'h33, 1'b0, 1'b1, 4'd1, 24'h333, 3'd0, 1'b0, 1'b0},
      '{19'h200, 8'h33, 1'b1, 1'b1, 4'd1, 24'h444, 3'd7, 1'b1, 1'b1},
      '{19'h30A, 8'h09, 1'b0, 1'b1, 4'd2, 24'h555, 3'd1, 1'b1, 1'b1},
      '{19'h305, 8'h09, 1'b1, 1'b1, 4'd2, 24'h666, 3'd4, 1'b0, 1'b1},
      '{19'h30A, 8'h08, 1'b0, 1'b0, 4'd0, 24'h000, 3'd0, 1'b0, 1'b0},
      '{19'h310, 8'h09, 1'b0, 1'b0, 4'd0, 24'h000, 3'd0, 1'b0, 1'b0},
      '{19'h000, 8'h00, 1'b0, 1'b1, 4'd4, 24'h000, 3'd0, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lo_word(input logic [23:0] pfn, input logic [2:0] c,
                                           input logic d, input logic v, input logic g);
      return (64'(pfn) << 6) | (64'(c) << 3) | (64'(d) << 2) | (64'(v) << 1) | 64'(g);
   endfunction

   function automatic logic [63:0] hi_word(input logic [18:0] vpn, input logic [7:0] asid);
      return (64'(vpn) << 11) | 64'(asid);
   endfunction

   task automatic wr_entry(input logic [4:0] idx, input logic [18:0] vpn, input logic [18:0] msk,
                           input logic [7:0] asid, input logic g,
                           input logic [23:0] pe, input logic [2:0] ce, input logic de, input logic ve,
                           input logic [23:0] po, input logic [2:0] co, input logic dd, input logic vo);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_mask = msk; wr_asid = asid; wr_glob = g;
      wr_pfn_even = pe; wr_attr_even = ce; wr_dirty_even = de; wr_valid_even = ve;
      wr_pfn_odd = po; wr_attr_odd = co; wr_dirty_odd = dd; wr_valid_odd = vo;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic search(input logic [18:0] vpn, input logic [7:0] asid, input logic odd);
      @(negedge clk);
      lk_vpn = vpn; lk_asid = asid; lk_odd = odd;
      pr_vpn = vpn; pr_asid = asid;
      #1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      rst_n = 1'b0;
      lk_vpn = '0; lk_asid = '0; lk_odd = 1'b0; pr_vpn = '0; pr_asid = '0;
      wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_mask = '0; wr_asid = '0; wr_glob = 1'b0;
      wr_pfn_even = '0; wr_attr_even = '0; wr_dirty_even = 1'b0; wr_valid_even = 1'b0;
      wr_pfn_odd = '0; wr_attr_odd = '0; wr_dirty_odd = 1'b0; wr_valid_odd = 1'b0;
      flush = 1'b0; nr_adv = 1'b0; rd_idx = '0; rd_use_nr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      rd_idx = 4'd5;
      #1;
      chk("R9 pointer after reset", 64'(nr_ptr), 64'h0);
      chk("R9 hi word after reset", 64'(rd_hi), 64'h0);
      chk("R9 lo word after reset", 64'(rd_lo_even), 64'h0);

      // Load the table
      wr_entry(5'd0, 19'h100, 19'h0, 8'h05, 1'b0, 24'h111, 3'd3, 1'b1, 1'b1, 24'h222, 3'd2, 1'b0, 1'b1);
      wr_entry(5'd1, 19'h200, 19'h0, 8'h00, 1'b1, 24'h333, 3'd0, 1'b0, 1'b0, 24'h444, 3'd7, 1'b1, 1'b1);
      wr_entry(5'd2, 19'h300, 19'hF, 8'h09, 1'b0, 24'h555, 3'd1, 1'b1, 1'b1, 24'h666, 3'd4, 1'b0, 1'b1);
      wr_entry(5'd3, 19'h305, 19'h0, 8'h09, 1'b0, 24'h777, 3'd5, 1'b1, 1'b1, 24'h888, 3'd6, 1'b1, 1'b1);

      // R6: packed read-back words
      rd_idx = 4'd0;
      #1;
      chk("R6 even low word e0", 64'(rd_lo_even), lo_word(24'h111, 3'd3, 1'b1, 1'b1, 1'b0));
      chk("R6 odd low word e0", 64'(rd_lo_odd), lo_word(24'h222, 3'd2, 1'b0, 1'b1, 1'b0));
      chk("R6 hi word e0", 64'(rd_hi), hi_word(19'h100, 8'h05));
      rd_idx = 4'd1;
      #1;
      chk("R6 even low word global e1", 64'(rd_lo_even), lo_word(24'h333, 3'd0, 1'b0, 1'b0, 1'b1));
      rd_idx = 4'd2;
      #1;
      chk("R6 mask word e2", 64'(rd_mask), 64'h7800);

      // R1 R2 R3 R8: vector table
      for (int i = 0; i < 10; i++) begin
         search(VECS[i].vpn, VECS[i].asid, VECS[i].odd);
         chk($sformatf("R1 hit vec%0d", i), 64'(lk_hit), 64'(VECS[i].hit));
         chk($sformatf("R3 probe vec%0d", i), 64'(pr_result),
             VECS[i].hit ? 64'({1'b0, VECS[i].idx}) : 64'h1F);
         if (VECS[i].hit) begin
            chk($sformatf("R2 index vec%0d", i), 64'(lk_idx), 64'(VECS[i].idx));
            chk($sformatf("R8 half fields vec%0d", i),
                64'({lk_pfn, lk_attr, lk_dirty, lk_valid}),
                64'({VECS[i].pfn, VECS[i].attr, VECS[i].dirty, VECS[i].valid}));
         end
      end

      // R2: overlapping entries 2 and 3, lowest index wins on probe
      search(19'h305, 8'h09, 1'b0);
      chk("R2 probe overlap", 64'(pr_result), 64'h02);

      // R4: out-of-range write is ignored
      wr_entry(5'd16, 19'h1234, 19'h0, 8'h01, 1'b1, 24'hABC, 3'd1, 1'b1, 1'b1, 24'hDEF, 3'd1, 1'b1, 1'b1);
      search(19'h1234, 8'h01, 1'b0);
      chk("R4 oob write no hit", 64'(lk_hit), 64'h0);
      rd_idx = 4'd0;
      #1;
      chk("R4 oob write e0 intact", 64'(rd_hi), hi_word(19'h100, 8'h05));

      // R4: overwrite entry 0
      wr_entry(5'd0, 19'h500, 19'h0, 8'h05, 1'b0, 24'h999, 3'd2, 1'b1, 1'b1, 24'hAAA, 3'd2, 1'b1, 1'b0);
      search(19'h100, 8'h05, 1'b0);
      chk("R4 old mapping gone", 64'(lk_hit), 64'h0);
      search(19'h500, 8'h05, 1'b1);
      chk("R4 new mapping", 64'({lk_hit, lk_idx, lk_pfn, lk_valid}),
          64'({1'b1, 4'd0, 24'hAAA, 1'b0}));

      // R7: pointer advance, wrap and read-back through pointer
      @(negedge clk);
      nr_adv = 1'b1;
      repeat (3) @(negedge clk);
      nr_adv = 1'b0;
      rd_use_nr = 1'b1;
      #1;
      chk("R7 pointer after 3", 64'(nr_ptr), 64'h3);
      chk("R7 read-back at pointer", 64'(rd_hi), hi_word(19'h305, 8'h09));
      nr_adv = 1'b1;
      repeat (13) @(negedge clk);
      nr_adv = 1'b0;
      #1;
      chk("R7 pointer wraps", 64'(nr_ptr), 64'h0);
      @(negedge clk);
      nr_adv = 1'b1;
      #1;
      chk("R7 read while advancing", 64'(rd_hi), hi_word(19'h500, 8'h05));
      @(negedge clk);
      nr_adv = 1'b0;
      #1;
      chk("R7 pointer after read-advance", 64'(nr_ptr), 64'h1);
      chk("R7 read-back follows pointer", 64'(rd_hi), hi_word(19'h200, 8'h00));

      // R5: flush with a simultaneous advance and write
      @(negedge clk);
      flush = 1'b1; nr_adv = 1'b1;
      wr_en = 1'b1; wr_idx = 5'd6; wr_vpn = 19'h777; wr_mask = '0; wr_asid = 8'h07; wr_glob = 1'b1;
      @(negedge clk);
      flush = 1'b0; nr_adv = 1'b0; wr_en = 1'b0;
      rd_use_nr = 1'b0; rd_idx = 4'd1;
      #1;
      chk("R5 pointer cleared", 64'(nr_ptr), 64'h0);
      chk("R5 entry words cleared", 64'({rd_hi, rd_lo_even}), 64'h0);
      rd_idx = 4'd6;
      #1;
      chk("R5 flush beats write", 64'(rd_hi), 64'h0);
      search(19'h200, 8'h33, 1'b0);
      chk("R5 global entry gone", 64'(lk_hit), 64'h0);
      search(19'h000, 8'h00, 1'b0);
      chk("R8 cleared entry still matches", 64'({pr_result, lk_valid}), 64'({5'd0, 1'b0}));

      done = 1'b1;
      summary();
   end
endmodule